// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog with two expiry stages. Software programs a timeout period in ticks, clears the halt control and then writes the reload register at regular intervals. Each pulse on the tick-enable input moves the countdown down by one. If software stops reloading, the first expiry raises a sticky status flag and restarts the count on its own. This gives software a second chance to react.

If the count expires again before any reload, the block raises a second-timeout flag. If the no-reboot control is clear, it also sends a single-cycle system reset request. After a reset request the block stops counting until its own reset. The status flags are cleared by writing 1 to them. The register bus is a plain address, write-enable and byte-strobe interface. Reads are combinational.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, the control register (address 0) reads 0x0003 (bit 0 halt = 1, bit 1 no-reboot = 1). The period register (address 1) reads 0x0004, the status register (address 3) reads 0x0000, the count (address 4) reads 4, and reset_req is low.
- R2: While the halt bit is 1, tick pulses leave the count unchanged.
- R3: The period register stores all 16 bits, and each byte is written only when its byte strobe is set (bus_be[0] for bits 7:0, bus_be[1] for bits 15:8). Only bits 9:0 set the reload value; bits 15:10 have no effect on counting.
- R4: While running, each tick pulse lowers the count by one. The tick pulse that arrives when the count is 1 or less is an expiry.
- R5: A write to address 2 with any byte strobe set loads the count from the period, whatever the written data. This write takes priority over a tick in the same cycle.
- R6: On the first expiry, status bit 0 is set and the count reloads from the period. No reset request is made.
- R7: Writing 1 to status bit 0, 1 or 2 with bus_be[0] set clears that bit. Bits written with 0, or written while bus_be[0] is low, are kept. A set event in the same cycle wins over the clear.
- R8: On a second expiry with no-reboot = 1, status bit 2 is set, the count reloads, and reset_req stays low.
- R9: A reload between two expiries cancels the second stage, so the next expiry counts as a first expiry again.
- R10: On a second expiry with no-reboot = 0, reset_req is high for exactly one cycle, and status bits 1 (boot) and 2 are set.
- R11: After a reset request, ticks no longer change the count and no further request is made until rst_n is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write enable |
| bus_be | input | 2 | Byte strobes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| tick_en | input | 1 | Countdown tick pulse |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions check on every cycle that:
- the count holds while halted or locked;
- a reset request lasts one cycle and only follows a second-stage expiry with no-reboot clear;
- the first-timeout flag goes up whenever the second stage is entered.

Only the bench scenarios can show the following:
- the exact number of ticks to each expiry;
- that the upper bits of the period register and the reload data have no effect;
- write-one-to-clear behaviour under different byte strobes;
- that a reload between expiries cancels the second stage.

// File: rtl/wdt_pkg.sv
// Shared constants for the two-stage watchdog: register addresses and
// status bit positions. Assumes a 16-bit data bus with two byte strobes.
package wdt_pkg;
    localparam int DATA_W = 16;
    localparam int BE_W   = DATA_W / 8;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_PERIOD = 3'd1,
        REG_RELOAD = 3'd2,
        REG_STATUS = 3'd3,
        REG_COUNT  = 3'd4
    } wdt_reg_e;

    localparam int CTRL_HALT   = 0;
    localparam int CTRL_NOREB  = 1;
    localparam int STS_FIRST   = 0;
    localparam int STS_BOOT    = 1;
    localparam int STS_SECOND  = 2;
    localparam int STS_W       = 3;
endpackage

// File: rtl/wdt_regs.sv
// Register file of the watchdog: control, period and sticky status, plus the
// read mux. Assumes set events arrive as single-cycle pulses from the counter.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int PERIOD_W       = 10,
    parameter int DEFAULT_PERIOD = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          bus_addr,
    input  logic                bus_we,
    input  logic [BE_W-1:0]     bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [PERIOD_W-1:0] count,
    input  logic                set_first,
    input  logic                set_boot,
    input  logic                set_second,
    output logic                halt,
    output logic                noreboot,
    output logic [PERIOD_W-1:0] period,
    output logic                reload,
    output logic [STS_W-1:0]    status
);
    logic [DATA_W-1:0] period_q;
    logic [1:0]        ctrl_q;
    logic [STS_W-1:0]  sts_q;
    logic [STS_W-1:0]  sts_set;
    logic              wr_ctrl, wr_period, wr_status;

    assign wr_ctrl   = bus_we && (bus_addr == REG_CTRL);
    assign wr_period = bus_we && (bus_addr == REG_PERIOD);
    assign wr_status = bus_we && (bus_addr == REG_STATUS) && bus_be[0];
    assign reload    = bus_we && (bus_addr == REG_RELOAD) && (|bus_be);

    assign sts_set[STS_FIRST]  = set_first;
    assign sts_set[STS_BOOT]   = set_boot;
    assign sts_set[STS_SECOND] = set_second;

    // Control bits: halt and no-reboot, written through byte 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= 2'b11;
        else if (wr_ctrl && bus_be[0])
            ctrl_q <= bus_wdata[1:0];
    end

    // Period register, one generate branch per byte lane.
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                period_q[8*b +: 8] <= 8'(DEFAULT_PERIOD >> (8*b));
            else if (wr_period && bus_be[b])
                period_q[8*b +: 8] <= bus_wdata[8*b +: 8];
        end
    end

    // Sticky status flags: set wins over write-one-to-clear.
    for (genvar i = 0; i < STS_W; i++) begin : g_sts
        always_ff @(posedge clk) begin
            if (!rst_n)
                sts_q[i] <= 1'b0;
            else if (sts_set[i])
                sts_q[i] <= 1'b1;
            else if (wr_status && bus_wdata[i])
                sts_q[i] <= 1'b0;
        end
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL:   bus_rdata[1:0]          = ctrl_q;
            REG_PERIOD: bus_rdata               = period_q;
            REG_STATUS: bus_rdata[STS_W-1:0]    = sts_q;
            REG_COUNT:  bus_rdata[PERIOD_W-1:0] = count;
            default:    bus_rdata               = '0;
        endcase
    end

    assign halt     = ctrl_q[CTRL_HALT];
    assign noreboot = ctrl_q[CTRL_NOREB];
    assign period   = period_q[PERIOD_W-1:0];
    assign status   = sts_q;
endmodule

// File: rtl/wdt_counter.sv
// Countdown and two-stage expiry logic. Assumes the reload input is a
// single-cycle pulse and tick is a qualified one-cycle enable.
module wdt_counter #(
    parameter int PERIOD_W       = 10,
    parameter int DEFAULT_PERIOD = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                halt,
    input  logic                noreboot,
    input  logic                reload,
    input  logic [PERIOD_W-1:0] period,
    output logic [PERIOD_W-1:0] count,
    output logic                stage2,
    output logic                locked,
    output logic                ev_first,
    output logic                ev_second,
    output logic                ev_boot,
    output logic                reset_req
);
    logic [PERIOD_W-1:0] cnt_q;
    logic                stage2_q, locked_q, req_q;
    logic                run_tick, expire;

    assign run_tick  = tick && !halt && !locked_q;
    assign expire    = run_tick && !reload && (cnt_q <= PERIOD_W'(1));
    assign ev_first  = expire && !stage2_q;
    assign ev_second = expire && stage2_q;
    assign ev_boot   = ev_second && !noreboot;

    // Countdown, stage tracking and the reset-request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= PERIOD_W'(DEFAULT_PERIOD);
            stage2_q <= 1'b0;
            locked_q <= 1'b0;
            req_q    <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (reload) begin
                cnt_q    <= period;
                stage2_q <= 1'b0;
            end else if (expire) begin
                cnt_q    <= period;
                stage2_q <= 1'b1;
                if (ev_boot) begin
                    req_q    <= 1'b1;
                    locked_q <= 1'b1;
                end
            end else if (run_tick) begin
                cnt_q <= cnt_q - PERIOD_W'(1);
            end
        end
    end

    assign count     = cnt_q;
    assign stage2    = stage2_q;
    assign locked    = locked_q;
    assign reset_req = req_q;
endmodule

// File: rtl/wdt_two_stage.sv
// Top of the two-stage watchdog: joins the register file and the countdown.
// Assumes tick_en is synchronous to clk and one cycle wide per tick.
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int PERIOD_W       = 10,
    parameter int DEFAULT_PERIOD = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_we,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        tick_en,
    output logic        reset_req
);
    logic                halt_w, noreb_w, reload_w, stage2_w, locked_w;
    logic                ev_first, ev_second, ev_boot;
    logic [PERIOD_W-1:0] period_w, count_w;
    logic [STS_W-1:0]    sts_w;

    wdt_regs #(.PERIOD_W(PERIOD_W), .DEFAULT_PERIOD(DEFAULT_PERIOD)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count_w),
        .set_first(ev_first), .set_boot(ev_boot), .set_second(ev_second),
        .halt(halt_w), .noreboot(noreb_w), .period(period_w),
        .reload(reload_w), .status(sts_w)
    );

    wdt_counter #(.PERIOD_W(PERIOD_W), .DEFAULT_PERIOD(DEFAULT_PERIOD)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_en),
        .halt(halt_w), .noreboot(noreb_w), .reload(reload_w),
        .period(period_w), .count(count_w),
        .stage2(stage2_w), .locked(locked_w),
        .ev_first(ev_first), .ev_second(ev_second), .ev_boot(ev_boot),
        .reset_req(reset_req)
    );
endmodule

// File: rtl/wdt_two_stage_chk.sv
// Checker for the two-stage watchdog, attached to the top through bind.
module wdt_two_stage_chk #(
    parameter int PERIOD_W = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reset_req,
    input logic                halt,
    input logic                locked,
    input logic                noreboot,
    input logic                reload,
    input logic                stage2,
    input logic [PERIOD_W-1:0] count,
    input logic [2:0]          status
);
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload) |=> $stable(count)); // R2

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !reload) |=> $stable(count)); // R11

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req); // R10

    AST_REQ_NEEDS_STAGE2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(stage2)); // R8

    AST_REQ_NEEDS_REBOOT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(!noreboot)); // R10

    AST_FIRST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage2) |-> status[0]); // R6

    AST_REQ_BOOT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (status[1] && status[2])); // R10

    AST_NO_REQ_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> !$rose(reset_req)); // R11
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.PERIOD_W(PERIOD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req),
    .halt(halt_w), .locked(locked_w), .noreboot(noreb_w),
    .reload(reload_w), .stage2(stage2_w), .count(count_w),
    .status(sts_w)
);

// File: tb/sim_wdt_two_stage.sv
module sim_wdt_two_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        reset_req;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int cycles = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    wdt_two_stage u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .reset_req(reset_req)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && reset_req) pulses <= pulses + 1;
    end

    initial begin
        wait (cycles > 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, act %0d cycles exp < 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act 0x%04h exp 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(posedge clk);
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(3'd0, v); chk("R1 ctrl", v, 16'h0003);
        rd(3'd1, v); chk("R1 period", v, 16'h0004);
        rd(3'd3, v); chk("R1 status", v, 16'h0000);
        rd(3'd4, v); chk("R1 count", v, 16'd4);
        chk("R1 reset_req", {15'd0, reset_req}, 16'd0);
    endtask

    task automatic t_halt;
        logic [15:0] v;
        ticks(5);
        rd(3'd4, v); chk("R2 halted count", v, 16'd4);
    endtask

    task automatic t_period;
        logic [15:0] v;
        wr(3'd1, 2'b11, 16'hFC07); rd(3'd1, v); chk("R3 full write", v, 16'hFC07);
        wr(3'd1, 2'b01, 16'h000A); rd(3'd1, v); chk("R3 low strobe", v, 16'hFC0A);
        wr(3'd1, 2'b10, 16'h0000); rd(3'd1, v); chk("R3 high strobe", v, 16'h000A);
        wr(3'd1, 2'b11, 16'hFC06);
        wr(3'd2, 2'b01, 16'h0000); rd(3'd4, v); chk("R3 upper bits ignored", v, 16'd6);
        wr(3'd1, 2'b11, 16'h0006);
    endtask

    task automatic t_run_first;
        logic [15:0] v;
        wr(3'd0, 2'b01, 16'h0002);
        ticks(1);
        wr(3'd2, 2'b10, 16'hABCD); rd(3'd4, v); chk("R5 reload data ignored", v, 16'd6);
        ticks(2); rd(3'd4, v); chk("R4 decrement", v, 16'd4);
        ticks(3); rd(3'd3, v); chk("R4 no expiry early", v, 16'h0000);
        ticks(1); rd(3'd3, v); chk("R6 first flag", v, 16'h0001);
        rd(3'd4, v); chk("R6 count reloaded", v, 16'd6);
        chk("R6 no request", 16'(pulses), 16'd0);
    endtask

    task automatic t_w1c;
        logic [15:0] v;
        wr(3'd3, 2'b00, 16'h0007); rd(3'd3, v); chk("R7 no strobe keeps", v, 16'h0001);
        wr(3'd3, 2'b01, 16'h0006); rd(3'd3, v); chk("R7 zero bit keeps", v, 16'h0001);
        wr(3'd3, 2'b01, 16'h0001); rd(3'd3, v); chk("R7 clear", v, 16'h0000);
    endtask

    task automatic t_second_noreboot;
        logic [15:0] v;
        ticks(6); rd(3'd3, v); chk("R8 second flag", v, 16'h0004);
        rd(3'd4, v); chk("R8 count reloaded", v, 16'd6);
        chk("R8 no request", 16'(pulses), 16'd0);
        wr(3'd3, 2'b01, 16'h0007);
    endtask

    task automatic t_reload_cancels;
        logic [15:0] v;
        wr(3'd2, 2'b01, 16'h0000);
        ticks(6); rd(3'd3, v); chk("R9 first", v, 16'h0001);
        wr(3'd0, 2'b01, 16'h0000);
        wr(3'd2, 2'b01, 16'h0000);
        ticks(6); rd(3'd3, v); chk("R9 stage cancelled", v, 16'h0001);
        chk("R9 no request", 16'(pulses), 16'd0);
    endtask

    task automatic t_reboot;
        logic [15:0] v;
        wr(3'd3, 2'b01, 16'h0007);
        wr(3'd2, 2'b01, 16'h0000);
        ticks(6);
        ticks(5); chk("R10 before second", 16'(pulses), 16'd0);
        ticks(1); chk("R10 req high", {15'd0, reset_req}, 16'd1);
        @(negedge clk); chk("R10 req one cycle", {15'd0, reset_req}, 16'd0);
        rd(3'd3, v); chk("R10 flags", v, 16'h0007);
        rd(3'd4, v);
        ticks(4);
        begin
            logic [15:0] w;
            rd(3'd4, w); chk("R11 frozen", w, v);
        end
        ticks(8); chk("R11 single request", 16'(pulses), 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_halt();
        t_period();
        t_run_first();
        t_w1c();
        t_second_noreboot();
        t_reload_cancels();
        t_reboot();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule